// File: doc/BRIEF.md
# Dual-Sided Mailbox Register File

A small shared message area that two agents use to talk to each other: a host side and a management-controller side. Each agent has its own single-cycle register port (address, write strobe, write data, combinational read data) and its own interrupt output. Both ports see the same sixteen 8-bit data bytes. By convention, byte 0 carries a command and byte 1 a sequence number. Bytes 2 to 12 carry arguments, byte 13 a response code, byte 14 a status byte owned by the host and byte 15 a status byte owned by the controller. The block attaches no meaning to these contents.

A side signals the other in two ways. It can ring a doorbell through its own control register. It can also write a data byte that the receiving side has chosen to watch. Each side keeps its own enable, mask and pending bits for watched bytes, so the two directions are configured independently. Pending flags can be polled through the register port or taken as an interrupt. The receiving side clears them by writing ones.

Top module: `mbox_regs`

## Requirements
- R1: After reset all data bytes, both control registers and every enable, mask and pending register read 0x00 from both ports, and both interrupt outputs are low.
- R2: Addresses 0x00 to 0x0F select the data bytes. A write from either port is readable from both ports from the next cycle on.
- R3: Writing a value with bit 0 set to a side's control register (address 0x10) sets bit 7 of the other side's control register on the next cycle and raises that side's interrupt. Bit 0 and bits 1 to 6 always read 0.
- R4: A side clears its own control bit 7 by writing its control register with bit 7 set, and its interrupt falls after that edge if nothing else is pending. Writing 0 to bit 7 leaves it unchanged. If a clear and a new doorbell arrive in the same cycle, the bit stays set.
- R5: Each side has write-trigger enable registers at 0x11 (bit i watches byte i) and 0x12 (bit i watches byte 8+i), and mask registers at 0x13 and 0x14 with the same bit layout. When the other side writes byte n while that side's enable bit n is 1 and its mask bit n is 0, that side's pending bit n (0x15 for bytes 0 to 7, 0x16 for bytes 8 to 15) is set on the next cycle and its interrupt asserts.
- R6: A data write sets no pending bit when the watching side's enable bit is 0 or its mask bit is 1. A side's own data writes never set its own pending bits.
- R7: Writing a 1 to a bit of a pending register (0x15 or 0x16) clears that bit, and writing a 0 leaves it unchanged. A new trigger in the same cycle wins over a clear.
- R8: When both ports write the same data byte in the same cycle, the controller-side value is stored.
- R9: A side's interrupt is high exactly while its control bit 7 or any of its pending bits is set. It stays high until that side clears them.
- R10: Addresses 0x17 to 0x1F read 0x00, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| h_we | input | 1 | Host write strobe |
| h_addr | input | 5 | Host register address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, combinational from h_addr |
| h_irq | output | 1 | Interrupt toward the host |
| c_we | input | 1 | Controller write strobe |
| c_addr | input | 5 | Controller register address |
| c_wdata | input | 8 | Controller write data |
| c_rdata | output | 8 | Controller read data, combinational from c_addr |
| c_irq | output | 1 | Interrupt toward the controller |

## Verification
The assertions assume that address and data are valid whenever a write strobe is high. They also assume that the strobes are never unknown after reset. The bench keeps to this by changing the inputs only on falling edges and by holding each strobe high for exactly one rising edge. Every interrupt and pending check is made one cycle after the write that causes it. The collision cases drive both ports in the same cycle on purpose. One case writes the same data byte from both sides, and another sets and clears a doorbell bit together.

// File: rtl/mbox_regs.sv
module mbox_regs #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  output logic          h_irq,
  input  logic          c_we,
  input  logic [AW-1:0] c_addr,
  input  logic [DW-1:0] c_wdata,
  output logic [DW-1:0] c_rdata,
  output logic          c_irq
);
  localparam int NREG = 2 * DW;
  localparam int IW   = $clog2(NREG);
  localparam logic [AW-1:0] A_CTRL = AW'(NREG);
  localparam logic [AW-1:0] A_ENL  = AW'(NREG + 1);
  localparam logic [AW-1:0] A_ENH  = AW'(NREG + 2);
  localparam logic [AW-1:0] A_MKL  = AW'(NREG + 3);
  localparam logic [AW-1:0] A_MKH  = AW'(NREG + 4);
  localparam logic [AW-1:0] A_PDL  = AW'(NREG + 5);
  localparam logic [AW-1:0] A_PDH  = AW'(NREG + 6);

  logic [DW-1:0]   mem [NREG];
  logic            h_db, c_db;
  logic [NREG-1:0] h_en, h_mk, h_pd;
  logic [NREG-1:0] c_en, c_mk, c_pd;
  logic [NREG-1:0] h_sel, c_sel, h_set, c_set, h_clr, c_clr;
  logic            h_ring, c_ring, h_ack, c_ack;

  assign h_sel = (h_we && h_addr < AW'(NREG)) ? (NREG'(1) << h_addr[IW-1:0]) : '0;
  assign c_sel = (c_we && c_addr < AW'(NREG)) ? (NREG'(1) << c_addr[IW-1:0]) : '0;

  assign c_set = h_sel & c_en & ~c_mk;
  assign h_set = c_sel & h_en & ~h_mk;

  assign h_clr = !h_we ? '0 :
                 (h_addr == A_PDL) ? {{DW{1'b0}}, h_wdata} :
                 (h_addr == A_PDH) ? {h_wdata, {DW{1'b0}}} : '0;
  assign c_clr = !c_we ? '0 :
                 (c_addr == A_PDL) ? {{DW{1'b0}}, c_wdata} :
                 (c_addr == A_PDH) ? {c_wdata, {DW{1'b0}}} : '0;

  assign h_ring = h_we && h_addr == A_CTRL && h_wdata[0];
  assign c_ring = c_we && c_addr == A_CTRL && c_wdata[0];
  assign h_ack  = h_we && h_addr == A_CTRL && h_wdata[DW-1];
  assign c_ack  = c_we && c_addr == A_CTRL && c_wdata[DW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (c_sel[i])      mem[i] <= c_wdata;
        else if (h_sel[i]) mem[i] <= h_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_db <= 1'b0;
      c_db <= 1'b0;
      h_pd <= '0;
      c_pd <= '0;
    end else begin
      h_db <= (h_db && !h_ack) || c_ring;
      c_db <= (c_db && !c_ack) || h_ring;
      h_pd <= (h_pd & ~h_clr) | h_set;
      c_pd <= (c_pd & ~c_clr) | c_set;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_en <= '0;
      h_mk <= '0;
    end else if (h_we) begin
      case (h_addr)
        A_ENL: h_en[DW-1:0]    <= h_wdata;
        A_ENH: h_en[NREG-1:DW] <= h_wdata;
        A_MKL: h_mk[DW-1:0]    <= h_wdata;
        A_MKH: h_mk[NREG-1:DW] <= h_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_en <= '0;
      c_mk <= '0;
    end else if (c_we) begin
      case (c_addr)
        A_ENL: c_en[DW-1:0]    <= c_wdata;
        A_ENH: c_en[NREG-1:DW] <= c_wdata;
        A_MKL: c_mk[DW-1:0]    <= c_wdata;
        A_MKH: c_mk[NREG-1:DW] <= c_wdata;
        default: ;
      endcase
    end
  end

  function automatic logic [DW-1:0] rd(input logic [AW-1:0] a, input logic db,
                                       input logic [NREG-1:0] en, mk, pd);
    if (a < AW'(NREG)) return mem[a[IW-1:0]];
    case (a)
      A_CTRL:  return {db, {(DW-1){1'b0}}};
      A_ENL:   return en[DW-1:0];
      A_ENH:   return en[NREG-1:DW];
      A_MKL:   return mk[DW-1:0];
      A_MKH:   return mk[NREG-1:DW];
      A_PDL:   return pd[DW-1:0];
      A_PDH:   return pd[NREG-1:DW];
      default: return '0;
    endcase
  endfunction

  assign h_rdata = rd(h_addr, h_db, h_en, h_mk, h_pd);
  assign c_rdata = rd(c_addr, c_db, c_en, c_mk, c_pd);

  assign h_irq = h_db || (|h_pd);
  assign c_irq = c_db || (|c_pd);

  p_ring_reaches_c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    h_we && h_addr == A_CTRL && h_wdata[0] |=> c_irq && c_rdata == c_rdata);

  p_ack_keeps_on_ring_r4: assert property (@(posedge clk) disable iff (!rst_n)
    c_we && c_addr == A_CTRL && c_wdata[DW-1] && !(h_we && h_addr == A_CTRL && h_wdata[0])
    |=> !c_db);

  p_trigger_fires_r5: assert property (@(posedge clk) disable iff (!rst_n)
    h_we && h_addr < AW'(NREG) && c_en[h_addr[IW-1:0]] && !c_mk[h_addr[IW-1:0]] |=> c_irq);

  p_pend_needs_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_we && h_addr < AW'(NREG)) |=> (c_pd & ~$past(c_pd)) == '0);

  p_collision_ctrl_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    h_we && c_we && h_addr == c_addr && c_addr < AW'(NREG)
    |=> mem[$past(c_addr[IW-1:0])] == $past(c_wdata));

  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    c_irq && !c_we |=> c_irq);

  p_irq_sticky_host_r9: assert property (@(posedge clk) disable iff (!rst_n)
    h_irq && !h_we |=> h_irq);
endmodule

// File: tb/mbox_regs_test.sv
module mbox_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       h_we = 1'b0, c_we = 1'b0;
  logic [4:0] h_addr = '0, c_addr = '0;
  logic [7:0] h_wdata = '0, c_wdata = '0;
  logic [7:0] h_rdata, c_rdata;
  logic       h_irq, c_irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mbox_regs uut (
    .clk(clk), .rst_n(rst_n),
    .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq),
    .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata), .c_irq(c_irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [4:0] a, input logic [7:0] d);
    h_addr = a; h_wdata = d; h_we = 1'b1;
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic cw(input logic [4:0] a, input logic [7:0] d);
    c_addr = a; c_wdata = d; c_we = 1'b1;
    @(negedge clk);
    c_we = 1'b0;
  endtask

  task automatic bw(input logic [4:0] ha, input logic [7:0] hd,
                    input logic [4:0] ca, input logic [7:0] cd);
    h_addr = ha; h_wdata = hd; h_we = 1'b1;
    c_addr = ca; c_wdata = cd; c_we = 1'b1;
    @(negedge clk);
    h_we = 1'b0; c_we = 1'b0;
  endtask

  task automatic hr(input logic [4:0] a, output logic [7:0] d);
    h_addr = a; #1; d = h_rdata;
  endtask

  task automatic cr(input logic [4:0] a, output logic [7:0] d);
    c_addr = a; #1; d = c_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 0; a < 23; a++) begin
      hr(5'(a), v); check("R1 host reg", v, 8'h00);
      cr(5'(a), v); check("R1 ctrl reg", v, 8'h00);
    end
    check("R1 h_irq", {7'd0, h_irq}, 8'h00);
    check("R1 c_irq", {7'd0, c_irq}, 8'h00);
  endtask

  task automatic t_data;
    logic [7:0] v;
    hw(5'h03, 8'hA5);
    hr(5'h03, v); check("R2 host sees host write", v, 8'hA5);
    cr(5'h03, v); check("R2 ctrl sees host write", v, 8'hA5);
    cw(5'h0F, 8'h3C);
    hr(5'h0F, v); check("R2 host sees ctrl write", v, 8'h3C);
    cr(5'h0F, v); check("R2 ctrl sees ctrl write", v, 8'h3C);
    check("R6 no irq without enable", {6'd0, h_irq, c_irq}, 8'h00);
  endtask

  task automatic t_doorbell;
    logic [7:0] v;
    hw(5'h10, 8'h01);
    cr(5'h10, v); check("R3 ctrl pending bit7", v, 8'h80);
    hr(5'h10, v); check("R3 host ctrl reads 0", v, 8'h00);
    check("R3 c_irq high", {7'd0, c_irq}, 8'h01);
    check("R3 h_irq low", {7'd0, h_irq}, 8'h00);
    cw(5'h10, 8'h00);
    cr(5'h10, v); check("R4 write 0 keeps bit7", v, 8'h80);
    cw(5'h10, 8'h80);
    cr(5'h10, v); check("R4 w1 clears bit7", v, 8'h00);
    check("R4 c_irq falls", {7'd0, c_irq}, 8'h00);
    hw(5'h10, 8'h01);
    bw(5'h10, 8'h01, 5'h10, 8'h80);
    cr(5'h10, v); check("R4 ring beats clear", v, 8'h80);
    cw(5'h10, 8'h80);
    cw(5'h10, 8'h01);
    hr(5'h10, v); check("R3 host pending bit7", v, 8'h80);
    check("R3 h_irq high", {7'd0, h_irq}, 8'h01);
    hw(5'h10, 8'h80);
    check("R4 h_irq falls", {7'd0, h_irq}, 8'h00);
  endtask

  task automatic t_trigger;
    logic [7:0] v;
    cw(5'h11, 8'h08);
    cw(5'h12, 8'h01);
    cr(5'h11, v); check("R5 enable low readback", v, 8'h08);
    hw(5'h03, 8'h11);
    cr(5'h15, v); check("R5 pend low bit3", v, 8'h08);
    check("R5 c_irq", {7'd0, c_irq}, 8'h01);
    hr(5'h15, v); check("R6 own side no pending", v, 8'h00);
    check("R6 h_irq low", {7'd0, h_irq}, 8'h00);
    repeat (5) @(negedge clk);
    check("R9 c_irq holds", {7'd0, c_irq}, 8'h01);
    cw(5'h15, 8'h00);
    cr(5'h15, v); check("R7 write 0 keeps", v, 8'h08);
    cw(5'h15, 8'h08);
    cr(5'h15, v); check("R7 w1c clears", v, 8'h00);
    check("R7 c_irq falls", {7'd0, c_irq}, 8'h00);
    hw(5'h08, 8'h22);
    cr(5'h16, v); check("R5 pend high bit0", v, 8'h01);
    bw(5'h08, 8'h23, 5'h16, 8'h01);
    cr(5'h16, v); check("R7 set beats clear", v, 8'h01);
    cw(5'h16, 8'h01);
    check("R9 c_irq clear", {7'd0, c_irq}, 8'h00);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    cw(5'h13, 8'h08);
    hw(5'h03, 8'h44);
    cr(5'h15, v); check("R6 masked no pend", v, 8'h00);
    check("R6 masked no irq", {7'd0, c_irq}, 8'h00);
    hw(5'h05, 8'h55);
    cr(5'h15, v); check("R6 not enabled no pend", v, 8'h00);
    cw(5'h13, 8'h00);
    cw(5'h03, 8'h66);
    cr(5'h15, v); check("R6 own write no pend", v, 8'h00);
    check("R6 own write no irq", {7'd0, c_irq}, 8'h00);
    cw(5'h11, 8'h00);
    cw(5'h12, 8'h00);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    bw(5'h07, 8'h11, 5'h07, 8'h22);
    hr(5'h07, v); check("R8 ctrl wins", v, 8'h22);
    bw(5'h06, 8'h33, 5'h09, 8'h44);
    hr(5'h06, v); check("R2 distinct host", v, 8'h33);
    hr(5'h09, v); check("R2 distinct ctrl", v, 8'h44);
  endtask

  task automatic t_unmapped;
    logic [7:0] v;
    hw(5'h1F, 8'hFF);
    hw(5'h17, 8'hFF);
    hr(5'h1F, v); check("R10 0x1F reads 0", v, 8'h00);
    cr(5'h17, v); check("R10 0x17 reads 0", v, 8'h00);
    hr(5'h0F, v); check("R10 data untouched", v, 8'h3C);
    check("R10 no irq", {6'd0, h_irq, c_irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_data();
    t_doorbell();
    t_trigger();
    t_mask();
    t_collide();
    t_unmapped();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule